// File: doc/BRIEF.md
# SPI Byte Master

This block is the master side of a byte-wide SPI link, as found in the serial port of a small controller. The host starts an exchange by writing one byte. The block then drives eight clock pulses on `sck`, sends the byte most significant bit first on `sdo`, and collects eight bits from `sdi`. When the exchange ends, the collected byte goes to a receive holding register and the buffer-full flag rises.

Three configuration inputs set the mode. `cpol` sets the idle level of the clock. `cke` picks whether data changes on the edge back to idle or on the edge away from idle. `smp` picks whether input is taken in the middle of the bit or at the end of the bit window. The end-of-bit choice is honoured for the last bit as well, so the least significant bit is never lost.

The clock comes from one of two sources. A divider gives the system clock divided by 4, 16 or 64. The other source advances one half period per pulse on a timer tick input, so `sck` runs at half the tick rate. A write that arrives while a byte is still shifting is refused and raises a sticky collision flag. Taking the enable low returns all shift state to idle.

Top module: `spi_byte_master`

## Requirements
- R1: With `en` high and no transfer running, a `wr_en` pulse is accepted at that clock edge. `busy` is high from the next cycle.
- R2: When `sck_src` is 0, 1 or 2, one half period of `sck` lasts 2, 8 or 32 system clocks. Half periods are counted from the accepting edge. Each transfer has exactly eight active pulses.
- R3: When `sck_src` is 3, the first sampled `tmr_tick` after acceptance only aligns the timer. Each later sampled tick ends one half period, so the first active phase is a full tick interval long.
- R4: Data leaves `sdo` MSB first, and bit 7 is on `sdo` from acceptance. With `cke`=1 the next bit appears on each return-to-idle edge. With `cke`=0 it appears on each edge away from idle, starting with the second such edge.
- R5: With `smp`=0, input is taken mid-bit: on the edge away from idle when `cke`=1, and on the return-to-idle edge when `cke`=0. With `smp`=1, input is taken where the bit window ends. With `cke`=0, bit 0 is taken one half period after the last return-to-idle edge.
- R6: A transfer lasts 16 half periods when `cke`=1 and 17 when `cke`=0. At its last edge, `busy` drops, `rx_data` takes the received byte and `buf_full` rises.
- R7: A `rd_en` pulse clears `buf_full` on the next cycle. A completing transfer in the same cycle wins.
- R8: A `wr_en` while `busy` sets `wcol`, and the write is discarded. The running transfer keeps its data, timing and eight pulses. `wcol` stays set until a `wcol_clr` pulse. Setting wins over clearing.
- R9: While `en` is low, writes are ignored and `busy` is forced low within one cycle, with `sck` at idle. After re-enable, the next write starts a clean transfer from bit 7.
- R10: Whenever no transfer is running, `sck` equals `cpol` as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with `clk` |
| en | input | 1 | Port enable; low holds shift logic idle |
| cpol | input | 1 | Idle level of `sck` |
| cke | input | 1 | 1: data changes on the return-to-idle edge; 0: data changes on the edge away from idle |
| smp | input | 1 | 0: sample mid-bit; 1: sample at end of bit window |
| sck_src | input | 2 | Clock source: 0 = /4, 1 = /16, 2 = /64, 3 = timer tick / 2 |
| tmr_tick | input | 1 | Timer tick, one half period per sampled high cycle |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | 8 | Transmit byte |
| rd_en | input | 1 | Read strobe; clears `buf_full` |
| wcol_clr | input | 1 | Clears the collision flag |
| rx_data | output | 8 | Last received byte |
| buf_full | output | 1 | Received byte waiting |
| wcol | output | 1 | Sticky write-collision flag |
| busy | output | 1 | Transfer in progress |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The bench models a slave that shows one byte in the first half of each bit window and a different byte in the second half. The received byte therefore shows which sample point was used, including for bit 0 at the end of the window. All eight combinations of `cpol`, `cke` and `smp` are run with the fastest divider. The two slower dividers and two timer-tick rates then show that the half-period length follows the selected source, and that the first timer tick only aligns. Extra runs cover a collision write in mid-transfer, an enable drop in mid-transfer and a write while disabled. These separate a correct refusal from extra pulses, and a clean restart from leftover bit-count state.

// File: rtl/spi_mst_pkg.sv
package spi_mst_pkg;
  typedef enum logic [1:0] {
    SRC_DIV_A = 2'd0,
    SRC_DIV_B = 2'd1,
    SRC_DIV_C = 2'd2,
    SRC_TICK  = 2'd3
  } sck_src_e;
endpackage

// File: rtl/spi_half_timer.sv
// Produces one pulse per SCK half period from the divider or the tick input.
module spi_half_timer
  import spi_mst_pkg::*;
#(
  parameter int DIV_A = 4,
  parameter int DIV_B = 16,
  parameter int DIV_C = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       run,
  input  logic [1:0] src,
  input  logic       tick_in,
  output logic       half_tick
);
  localparam int MAXH = DIV_C / 2;
  localparam int CW   = $clog2(MAXH + 1);

  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          align_q, align_d;

  always_comb begin
    case (src)
      SRC_DIV_A: lim = CW'(DIV_A / 2 - 1);
      SRC_DIV_B: lim = CW'(DIV_B / 2 - 1);
      default:   lim = CW'(DIV_C / 2 - 1);
    endcase
  end

  always_comb begin
    cnt_d     = cnt_q;
    align_d   = align_q;
    half_tick = 1'b0;
    if (start) begin
      cnt_d   = '0;
      align_d = (src == SRC_TICK);
    end else if (!run) begin
      cnt_d   = '0;
      align_d = 1'b0;
    end else if (src == SRC_TICK) begin
      if (tick_in) begin
        if (align_q) align_d   = 1'b0;
        else         half_tick = 1'b1;
      end
    end else if (cnt_q == lim) begin
      cnt_d     = '0;
      half_tick = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      align_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      align_q <= align_d;
    end
  end
endmodule

// File: rtl/spi_shift_core.sv
// Half-period sequencer, transmit and receive shifters, registered SCK.
module spi_shift_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         start,
  input  logic [W-1:0] load_word,
  input  logic         half_tick,
  input  logic         cpol,
  input  logic         cke,
  input  logic         smp,
  input  logic         sdi,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_word,
  output logic         sdo,
  output logic         sck
);
  localparam int HALVES = 2 * W;
  localparam int PHW    = $clog2(HALVES + 2);

  logic           busy_q, busy_d;
  logic [PHW-1:0] ph_q, ph_d, nxt, last, lo, hi;
  logic [W-1:0]   tx_q, tx_d, rx_q, rx_d;
  logic           sck_q, sck_d;
  logic           off, adv, samp, shft;

  // cke=0 moves every bit window one half period later
  assign off  = ~cke;
  assign nxt  = ph_q + 1'b1;
  assign last = PHW'(HALVES) + PHW'(off);
  assign lo   = PHW'(off) + PHW'(smp);
  assign hi   = PHW'(HALVES - 1) + lo;
  assign adv  = en & busy_q & half_tick;
  assign samp = adv & (nxt[0] ^ off ^ smp) & (nxt > lo) & (nxt <= hi);
  assign shft = adv & ~(nxt[0] ^ off) & (nxt >= PHW'(2) + PHW'(off))
              & (nxt <= PHW'(HALVES - 2) + PHW'(off));
  assign done = adv & (nxt == last);

  always_comb begin
    busy_d = busy_q;
    ph_d   = ph_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    if (!en) begin
      busy_d = 1'b0;
      ph_d   = '0;
    end else if (start) begin
      busy_d = 1'b1;
      ph_d   = '0;
      tx_d   = load_word;
      rx_d   = '0;
    end else if (adv) begin
      ph_d = nxt;
      if (done) busy_d = 1'b0;
      if (shft) tx_d = {tx_q[W-2:0], 1'b0};
      if (samp) rx_d = {rx_q[W-2:0], sdi};
    end
    sck_d = cpol ^ (busy_d & ph_d[0] & (ph_d < PHW'(HALVES)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      sck_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      ph_q   <= ph_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      sck_q  <= sck_d;
    end
  end

  assign busy    = busy_q;
  assign rx_word = rx_d;
  assign sdo     = tx_q[W-1];
  assign sck     = sck_q;
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int W     = 8,
  parameter int DIV_A = 4,
  parameter int DIV_B = 16,
  parameter int DIV_C = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         cpol,
  input  logic         cke,
  input  logic         smp,
  input  logic [1:0]   sck_src,
  input  logic         tmr_tick,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  input  logic         wcol_clr,
  output logic [W-1:0] rx_data,
  output logic         buf_full,
  output logic         wcol,
  output logic         busy,
  output logic         sck,
  output logic         sdo,
  input  logic         sdi
);
  logic         core_busy, accept, half_tick, xfer_done;
  logic [W-1:0] rx_word, rxb_q, rxb_d;
  logic         full_q, full_d, wcol_q, wcol_d;

  assign accept = en & wr_en & ~core_busy;

  spi_half_timer #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(accept), .run(core_busy),
    .src(sck_src), .tick_in(tmr_tick), .half_tick(half_tick)
  );

  spi_shift_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .en(en), .start(accept), .load_word(wr_data),
    .half_tick(half_tick), .cpol(cpol), .cke(cke), .smp(smp), .sdi(sdi),
    .busy(core_busy), .done(xfer_done), .rx_word(rx_word), .sdo(sdo), .sck(sck)
  );

  always_comb begin
    rxb_d  = rxb_q;
    full_d = full_q;
    wcol_d = wcol_q;
    if (xfer_done) begin
      rxb_d  = rx_word;
      full_d = 1'b1;
    end else if (rd_en) begin
      full_d = 1'b0;
    end
    if (en && wr_en && core_busy) wcol_d = 1'b1;
    else if (wcol_clr)            wcol_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxb_q  <= '0;
      full_q <= 1'b0;
      wcol_q <= 1'b0;
    end else begin
      rxb_q  <= rxb_d;
      full_q <= full_d;
      wcol_q <= wcol_d;
    end
  end

  assign rx_data  = rxb_q;
  assign buf_full = full_q;
  assign wcol     = wcol_q;
  assign busy     = core_busy;
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk #(
  parameter int W = 8
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic cpol,
  input logic wr_en,
  input logic rd_en,
  input logic busy,
  input logic sck,
  input logic wcol,
  input logic buf_full,
  input logic done
);
  logic       armed, act_d, rise;
  logic [7:0] pcnt;

  assign rise = (sck ^ cpol) & ~act_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      act_d <= 1'b0;
      pcnt  <= '0;
    end else begin
      armed <= 1'b1;
      act_d <= sck ^ cpol;
      if (!busy)     pcnt <= '0;
      else if (rise) pcnt <= pcnt + 1'b1;
    end
  end

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    en && wr_en && !busy |=> busy);
  assert_eight_pulses_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pcnt + 8'(rise)) == 8'(W));
  assert_done_sets_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> buf_full && !busy);
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !done |=> !buf_full);
  assert_collision_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en && wr_en && busy |=> wcol);
  assert_disable_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);
  assert_idle_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !busy && $stable(cpol) |-> sck == cpol);
endmodule

bind spi_byte_master spi_byte_master_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .wr_en(wr_en),
  .rd_en(rd_en), .busy(busy), .sck(sck), .wcol(wcol),
  .buf_full(buf_full), .done(xfer_done)
);

// File: tb/tb_spi_byte_master.sv
module tb_spi_byte_master;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n, en, cpol, cke, smp, wr_en, rd_en, wcol_clr;
  logic [1:0] sck_src;
  logic [7:0] wr_data, rx_data;
  logic       tmr_tick = 1'b0;
  logic       sdi = 1'b0;
  logic       buf_full, wcol, busy, sck, sdo;

  always #(CLK_P/2) clk = ~clk;

  spi_byte_master dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .cke(cke), .smp(smp),
    .sck_src(sck_src), .tmr_tick(tmr_tick), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .wcol_clr(wcol_clr), .rx_data(rx_data), .buf_full(buf_full),
    .wcol(wcol), .busy(busy), .sck(sck), .sdo(sdo), .sdi(sdi)
  );

  int n_cmp = 0, n_bad = 0, pulses = 0, tk = 0, tick_per = 0;
  bit run_chk = 0, prev_act = 0;
  bit m_busy, m_align, m_full, m_wcol, m_sck;
  int m_ph, m_cnt;
  logic [7:0] m_tx, m_rxd, sa, sb;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // timer tick source
  always @(posedge clk) begin
    #1;
    tk++;
    tmr_tick = (tick_per > 0) && (tk % tick_per == 0);
  end

  // behavioural reference model and slave
  always @(posedge clk) begin
    bit tick, fin;
    int off, hh, k;
    if (!rst_n) begin
      m_busy = 0; m_align = 0; m_full = 0; m_wcol = 0; m_sck = 0;
      m_ph = 0; m_cnt = 0; m_tx = 0; m_rxd = 0;
      sdi <= 1'b0;
    end else begin
      off = cke ? 0 : 1; tick = 0; fin = 0;
      if (m_busy && en && wr_en) m_wcol = 1;
      else if (wcol_clr)         m_wcol = 0;
      if (!en) begin
        m_busy = 0; m_ph = 0;
      end else if (!m_busy) begin
        if (wr_en) begin
          m_busy = 1; m_ph = 0; m_cnt = 0; m_align = (sck_src == 2'd3); m_tx = wr_data;
        end
      end else begin
        if (sck_src == 2'd3) begin
          if (tmr_tick) begin
            if (m_align) m_align = 0; else tick = 1;
          end
        end else begin
          hh = (sck_src == 2'd0) ? 2 : (sck_src == 2'd1) ? 8 : 32;
          m_cnt++;
          if (m_cnt == hh) begin m_cnt = 0; tick = 1; end
        end
        if (tick) begin
          m_ph++;
          if (m_ph == 16 + off) begin m_busy = 0; fin = 1; end
        end
      end
      if (fin) begin m_full = 1; m_rxd = smp ? sb : sa; end
      else if (rd_en) m_full = 0;
      m_sck = cpol ^ (m_busy && (m_ph % 2 == 1) && m_ph < 16);
      k = m_ph - off;
      if (m_busy && k >= 0 && k < 16)
        sdi <= (k % 2 == 0) ? sa[7 - k/2] : sb[7 - k/2];
      else
        sdi <= 1'b0;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    int j, off;
    if (rst_n && run_chk) begin
      off = cke ? 0 : 1;
      chk(busy === m_busy, "R6 busy", busy, m_busy);
      chk(sck === m_sck, (sck_src == 2'd3) ? "R3 sck" : "R2 sck", sck, m_sck);
      if (m_busy) begin
        j = (m_ph < off) ? 0 : (m_ph - off) / 2;
        if (j > 7) j = 7;
        chk(sdo === m_tx[7-j], "R4 sdo", sdo, m_tx[7-j]);
      end
      chk(buf_full === m_full, "R7 buf_full", buf_full, m_full);
      chk(rx_data === m_rxd, "R5 rx_data", rx_data, m_rxd);
      chk(wcol === m_wcol, "R8 wcol", wcol, m_wcol);
      if ((sck ^ cpol) && !prev_act) pulses++;
      prev_act = sck ^ cpol;
    end
  end

  task automatic set_cfg(input bit p, input bit e, input bit s, input logic [1:0] src);
    @(posedge clk); #1;
    cpol = p; cke = e; smp = s; sck_src = src;
    repeat (2) @(posedge clk);
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 2000; g++) begin
      @(posedge clk); #1;
      if (!m_busy) break;
    end
  endtask

  task automatic run_xfer(input logic [7:0] d, input logic [7:0] a, input logic [7:0] b);
    sa = a; sb = b; pulses = 0;
    @(posedge clk); #1 wr_en = 1; wr_data = d;
    @(posedge clk); #1 wr_en = 0;
    @(negedge clk);
    chk(busy === 1'b1, "R1 accept", busy, 1);
    wait_idle();
    @(negedge clk);
    chk(rx_data === (smp ? b : a), "R5 received byte", rx_data, smp ? b : a);
    chk(buf_full === 1'b1, "R6 full at end", buf_full, 1);
    chk(pulses == 8, "R2 pulse count", pulses, 8);
    @(posedge clk); #1 rd_en = 1;
    @(posedge clk); #1 rd_en = 0;
    @(negedge clk);
    chk(buf_full === 1'b0, "R7 read clears", buf_full, 0);
  endtask

  initial begin
    #(CLK_P * 190000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; en = 0; cpol = 0; cke = 1; smp = 0; sck_src = 0;
    wr_en = 0; wr_data = 0; rd_en = 0; wcol_clr = 0;
    sa = 8'h00; sb = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy === 1'b0, "R1 reset busy", busy, 0);
    chk(sck === 1'b0, "R10 reset sck", sck, 0);
    chk(buf_full === 1'b0, "R6 reset full", buf_full, 0);
    chk(wcol === 1'b0, "R8 reset wcol", wcol, 0);
    chk(rx_data === 8'h00, "R5 reset rx", rx_data, 0);
    @(posedge clk); #1 rst_n = 1; run_chk = 1;
    @(posedge clk); #1 en = 1;

    // all mode combinations, fastest divider
    for (int m = 0; m < 8; m++) begin
      set_cfg(m[2], m[1], m[0], 2'd0);
      run_xfer(8'hA5 ^ 8'(m * 17), 8'h3C ^ 8'(m), 8'hC1 ^ 8'(m * 5));
    end
    // slower dividers, end-of-bit sampling with late bit windows
    set_cfg(0, 0, 1, 2'd1); run_xfer(8'h81, 8'h0F, 8'h01);
    set_cfg(1, 1, 1, 2'd2); run_xfer(8'h7E, 8'hF0, 8'h81);
    // timer source
    tick_per = 3; set_cfg(0, 1, 0, 2'd3); run_xfer(8'h5A, 8'h96, 8'h69);
    tick_per = 5; set_cfg(1, 0, 1, 2'd3); run_xfer(8'hC3, 8'h12, 8'hED);
    tick_per = 0;

    // R8 collision in mid transfer
    set_cfg(0, 1, 1, 2'd1);
    sa = 8'h44; sb = 8'hB7; pulses = 0;
    @(posedge clk); #1 wr_en = 1; wr_data = 8'hE2;
    @(posedge clk); #1 wr_en = 0;
    repeat (20) @(posedge clk);
    #1 wr_en = 1; wr_data = 8'h11;
    @(posedge clk); #1 wr_en = 0;
    @(negedge clk);
    chk(wcol === 1'b1, "R8 collision flag", wcol, 1);
    wait_idle();
    @(negedge clk);
    chk(rx_data === 8'hB7, "R8 transfer unaffected", rx_data, 8'hB7);
    chk(pulses == 8, "R8 no extra pulses", pulses, 8);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(busy === 1'b0 && wcol === 1'b1, "R8 discarded and sticky", {busy, wcol}, 1);
    @(posedge clk); #1 wcol_clr = 1; rd_en = 1;
    @(posedge clk); #1 wcol_clr = 0; rd_en = 0;
    @(negedge clk);
    chk(wcol === 1'b0, "R8 clear", wcol, 0);

    // R9 enable drop in mid transfer
    set_cfg(1, 0, 0, 2'd1);
    sa = 8'hFF; sb = 8'hFF;
    @(posedge clk); #1 wr_en = 1; wr_data = 8'h00;
    @(posedge clk); #1 wr_en = 0;
    repeat (30) @(posedge clk);
    #1 en = 0;
    @(posedge clk);
    @(negedge clk);
    chk(busy === 1'b0, "R9 disable idles", busy, 0);
    @(negedge clk);
    chk(sck === 1'b1, "R9 sck idle after disable", sck, 1);
    // R9 writes while disabled ignored
    @(posedge clk); #1 wr_en = 1; wr_data = 8'h33;
    @(posedge clk); #1 wr_en = 0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && buf_full === 1'b0, "R9 write ignored", {busy, buf_full}, 0);
    @(posedge clk); #1 en = 1;
    run_xfer(8'h96, 8'h5B, 8'hA4);

    // R10 idle level follows cpol
    set_cfg(1, 1, 0, 2'd0);
    @(negedge clk);
    chk(sck === 1'b1, "R10 idle high", sck, 1);
    set_cfg(0, 1, 0, 2'd0);
    @(negedge clk);
    chk(sck === 1'b0, "R10 idle low", sck, 0);

    repeat (3) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule